// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sleep Wakeup

This block recovers asynchronous NRZ characters from a single serial input line. A built-in divider turns the bus clock into a sample enable running at sixteen times the bit rate. A small state machine hunts for a falling edge and confirms the start bit at its centre. It then takes three samples around the middle of every bit and votes on them. Each finished character is handed to a holding register, together with its error flags.

The character length is 8 or 9 data bits. An optional parity bit, even or odd, follows the data. The holding register shows a full flag and flags for noise, framing, overrun, parity and idle line. Every flag is cleared by a one-cycle acknowledge input.

A sleep request puts the receiver into a mode where finished characters are thrown away. One of two conditions ends the sleep. In idle wake mode, the first idle line ends it. In address wake mode, the first character whose top data bit is 1 ends it, and that character is kept.

Top module: `uart_wake_rx`

## Requirements
- R1: With a divisor D greater than zero, one sample enable occurs every D clocks, so one bit lasts 16·D clocks. With D equal to zero, no sample enable occurs and nothing is received.
- R2: A frame is a low start bit, then the data bits least significant first, then a high stop bit. In 8-bit mode the data appears on rx_word[7:0] with rx_word[8]=0. In 9-bit mode all of rx_word[8:0] is filled. rx_full rises when a frame completes.
- R3: Each bit takes the majority of the samples at positions 7, 8 and 9 of its 16. If the three samples disagree in any bit of a frame, err_noise is set for that frame.
- R4: If the start bit's vote comes out high, the receiver returns to hunting. Nothing is delivered and the idle logic is not armed.
- R5: With par_on=1, one parity bit sits between the data and the stop bit. With par_odd=0 the count of ones over data plus parity must be even, and with par_odd=1 it must be odd. A mismatch sets err_parity. With par_on=0 there is no parity bit.
- R6: A stop bit whose vote is low sets err_frame. The word is still delivered and rx_full is still set.
- R7: If a frame completes while rx_full is 1, err_overrun is set, the held word stays and the new word is lost.
- R8: A one-cycle pulse on flag_ack clears rx_full and every error and idle flag.
- R9: After a confirmed start, idle_seen sets once a full frame time of high samples has been counted. A frame time is 16 × (total bits of the configured frame). The flag sets only once for each burst of activity.
- R10: With idle_after_stop=0, the idle count runs over every high sample since the last low one, including those inside a frame. With idle_after_stop=1, it counts only while rx_busy is 0.
- R11: rx_busy is 1 from the detection of a falling edge until the stop bit has been evaluated, and 0 otherwise.
- R12: A pulse on sleep_req sets asleep. While asleep, completed frames change neither rx_full nor rx_word. With wake_on_addr=0, an idle line clears asleep without setting idle_seen, and the next frame is received.
- R13: With wake_on_addr=1, a frame whose top data bit is 0 is discarded while asleep. A frame whose top data bit is 1 clears asleep and is loaded. An idle line does not wake the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| rx_in | input | 1 | Serial input line, idle high |
| baud_div | input | 13 | Bit-rate divisor, 0 stops the sample enable |
| len9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_on | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| idle_after_stop | input | 1 | 1 counts idle only outside frames |
| wake_on_addr | input | 1 | 1 address-mark wake, 0 idle-line wake |
| sleep_req | input | 1 | Pulse to enter sleep |
| flag_ack | input | 1 | Pulse to clear the full and all other flags |
| rx_word | output | 9 | Held received word |
| rx_full | output | 1 | Held word is valid |
| err_noise | output | 1 | Sample disagreement in held frame |
| err_frame | output | 1 | Stop bit read low in held frame |
| err_overrun | output | 1 | A frame was lost while full |
| err_parity | output | 1 | Parity mismatch in held frame |
| idle_seen | output | 1 | Idle line detected |
| rx_busy | output | 1 | Frame in progress |
| asleep | output | 1 | Sleep mode active |

## Verification
The hardest case to reach from the ports is a disagreement among the three centre samples of one bit without flipping the bit's vote. The stimulus uses a divisor of 1, so the delay from the input through the synchronizer to edge detection is fixed. A single-clock glitch placed on the ninth clock of a chosen bit then always falls inside the three-sample window. The idle-count modes are told apart by sending an all-ones character and looking at idle_seen at one instant between the two expected set times. The sleep tests first wait long enough for any earlier idle detection to be used up, so the only wake source left is the frame under test.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam int OVS      = 16;
  localparam int SMP_A    = OVS / 2 - 1;
  localparam int WMAX     = 9;
  localparam int BITS_MAX = 1 + WMAX + 1 + 1;
  localparam int SUB_W    = $clog2(OVS);
  localparam int IDLE_W   = $clog2(OVS * BITS_MAX + 1);

  typedef enum logic [1:0] {RX_HUNT, RX_START, RX_DATA, RX_STOP} rx_phase_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a ^ b) | (b ^ c);
  endfunction

  // data bits plus optional parity bit
  function automatic logic [3:0] payload_bits(input logic nine, input logic par);
    return 4'd8 + {3'b000, nine} + {3'b000, par};
  endfunction

  // samples in one whole frame: start + payload + stop
  function automatic logic [IDLE_W-1:0] frame_samples(input logic nine, input logic par);
    return IDLE_W'(OVS * (int'(payload_bits(nine, par)) + 2));
  endfunction

  function automatic logic parity_good(input logic [8:0] d, input logic nine,
                                       input logic odd, input logic pbit);
    logic x;
    x = (^d[7:0]) ^ (nine & d[8]) ^ pbit;
    return odd ? x : ~x;
  endfunction
endpackage

// File: rtl/urx_baud.sv
module urx_baud #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             running;
  logic             at_end;

  assign running = divisor != '0;
  assign at_end  = cnt >= (divisor - DIV_W'(1));
  assign tick    = running && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!running || at_end) cnt <= '0;
    else                         cnt <= cnt + DIV_W'(1);
  end

  // R1
  baud_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(tick) && $stable(divisor)) |-> (divisor == DIV_W'(1)));
endmodule

// File: rtl/urx_frame.sv
module urx_frame
  import urx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxs,
  input  logic       nine,
  input  logic       par_on,
  input  logic       par_odd,
  output logic       done,
  output logic [8:0] word,
  output logic       noise,
  output logic       fail_stop,
  output logic       bad_par,
  output logic       active,
  output logic       start_ok
);
  rx_phase_e        phase;
  logic [SUB_W-1:0] sub;
  logic [3:0]       bidx;
  logic [1:0]       early;
  logic [9:0]       shreg;
  logic             noise_acc;
  logic [3:0]       nbits;
  logic             at_vote;
  logic             at_last;
  logic             vote;
  logic             split;
  logic [8:0]       dword;
  logic             pbit;

  assign nbits   = payload_bits(nine, par_on);
  assign at_vote = sub == SUB_W'(SMP_A + 2);
  assign at_last = sub == SUB_W'(OVS - 1);
  assign vote    = vote3(early[0], early[1], rxs);
  assign split   = split3(early[0], early[1], rxs);
  assign dword   = nine ? shreg[8:0] : {1'b0, shreg[7:0]};
  assign pbit    = nine ? shreg[9] : shreg[8];
  assign active  = phase != RX_HUNT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= RX_HUNT; sub <= '0; bidx <= '0; early <= '0; shreg <= '0;
      noise_acc <= 1'b0; done <= 1'b0; word <= '0; noise <= 1'b0;
      fail_stop <= 1'b0; bad_par <= 1'b0; start_ok <= 1'b0;
    end else begin
      done     <= 1'b0;
      start_ok <= 1'b0;
      if (tick) begin
        if (phase == RX_HUNT) begin
          if (!rxs) begin
            phase     <= RX_START;
            sub       <= SUB_W'(1);
            noise_acc <= 1'b0;
          end
        end else begin
          sub <= sub + SUB_W'(1);
          if (sub == SUB_W'(SMP_A))     early[0] <= rxs;
          if (sub == SUB_W'(SMP_A + 1)) early[1] <= rxs;
          if (at_vote) begin
            case (phase)
              RX_START: begin
                if (vote) phase <= RX_HUNT;
                else begin
                  noise_acc <= split;
                  start_ok  <= 1'b1;
                  bidx      <= '0;
                end
              end
              RX_DATA: begin
                shreg[bidx] <= vote;
                noise_acc   <= noise_acc | split;
              end
              RX_STOP: begin
                done      <= 1'b1;
                word      <= dword;
                noise     <= noise_acc | split;
                fail_stop <= ~vote;
                bad_par   <= par_on && !parity_good(dword, nine, par_odd, pbit);
                phase     <= RX_HUNT;
              end
              default: ;
            endcase
          end
          if (at_last) begin
            if (phase == RX_START) phase <= RX_DATA;
            else if (phase == RX_DATA) begin
              if (bidx == nbits - 4'd1) phase <= RX_STOP;
              else                      bidx  <= bidx + 4'd1;
            end
          end
        end
      end
    end
  end

  // R11
  done_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);
  // R2
  bit_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == RX_DATA) |-> (bidx < nbits));
  // R4
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase == RX_START && at_vote && vote) |=> (!active && !start_ok && !done));
endmodule

// File: rtl/urx_idle.sv
module urx_idle
  import urx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxs,
  input  logic active,
  input  logic start_ok,
  input  logic after_stop,
  input  logic nine,
  input  logic par_on,
  output logic idle_evt
);
  logic [IDLE_W-1:0] run;
  logic [IDLE_W-1:0] limit;
  logic              armed;
  logic              hold_off;
  logic              hit;

  assign limit    = frame_samples(nine, par_on);
  assign hold_off = !rxs || (after_stop && active);
  assign hit      = tick && !hold_off && armed && (run == limit - IDLE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0; armed <= 1'b0; idle_evt <= 1'b0;
    end else begin
      idle_evt <= hit;
      if (tick) begin
        if (hold_off)         run <= '0;
        else if (run < limit) run <= run + IDLE_W'(1);
      end
      if (start_ok) armed <= 1'b1;
      else if (hit) armed <= 1'b0;
    end
  end

  // R9
  idle_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |=> !idle_evt);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (after_stop && active && $stable(after_stop)) |=> !idle_evt);
endmodule

// File: rtl/urx_hold.sv
module urx_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  logic [8:0] word,
  input  logic       noise,
  input  logic       fail_stop,
  input  logic       bad_par,
  input  logic       idle_evt,
  input  logic       ack,
  input  logic       sleep_req,
  input  logic       addr_wake,
  input  logic       nine,
  output logic [8:0] data,
  output logic       full,
  output logic       f_noise,
  output logic       f_frame,
  output logic       f_over,
  output logic       f_par,
  output logic       f_idle,
  output logic       asleep
);
  logic msb;
  logic wake_addr_hit;
  logic wake_idle_hit;
  logic take;
  logic still_full;

  assign msb           = nine ? word[8] : word[7];
  assign wake_addr_hit = asleep && addr_wake && done && msb;
  assign wake_idle_hit = asleep && !addr_wake && idle_evt;
  assign take          = done && (!asleep || wake_addr_hit);
  assign still_full    = full && !ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0; full <= 1'b0; f_noise <= 1'b0; f_frame <= 1'b0;
      f_over <= 1'b0; f_par <= 1'b0; f_idle <= 1'b0; asleep <= 1'b0;
    end else begin
      if (sleep_req)                          asleep <= 1'b1;
      else if (wake_addr_hit || wake_idle_hit) asleep <= 1'b0;
      if (ack) begin
        full <= 1'b0; f_noise <= 1'b0; f_frame <= 1'b0;
        f_over <= 1'b0; f_par <= 1'b0; f_idle <= 1'b0;
      end
      if (take) begin
        if (still_full) f_over <= 1'b1;
        else begin
          data    <= word;
          full    <= 1'b1;
          f_noise <= noise;
          f_frame <= fail_stop;
          f_par   <= bad_par;
        end
      end
      if (idle_evt && !asleep) f_idle <= 1'b1;
    end
  end

  // R7
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && take && !ack) |=> (f_over && full && $stable(data)));
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !done && !idle_evt) |=> (!full && !f_over && !f_noise && !f_frame && !f_par && !f_idle));
  // R12
  sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && done && !(addr_wake && msb) && !ack) |=> ($stable(full) && $stable(data)));
  // R12
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && idle_evt && !addr_wake && !sleep_req && !ack) |=> (!asleep && $stable(f_idle)));
  // R13
  addr_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && addr_wake && !done && !sleep_req) |=> asleep);
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             len9,
  input  logic             par_on,
  input  logic             par_odd,
  input  logic             idle_after_stop,
  input  logic             wake_on_addr,
  input  logic             sleep_req,
  input  logic             flag_ack,
  output logic [8:0]       rx_word,
  output logic             rx_full,
  output logic             err_noise,
  output logic             err_frame,
  output logic             err_overrun,
  output logic             err_parity,
  output logic             idle_seen,
  output logic             rx_busy,
  output logic             asleep
);
  logic [1:0] sync_q;
  logic       rxs;
  logic       tick;
  logic       done;
  logic [8:0] word;
  logic       noise;
  logic       fail_stop;
  logic       bad_par;
  logic       active;
  logic       start_ok;
  logic       idle_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_in};
  end
  assign rxs = sync_q[1];

  urx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(baud_div), .tick(tick));

  urx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxs(rxs), .nine(len9),
    .par_on(par_on), .par_odd(par_odd), .done(done), .word(word),
    .noise(noise), .fail_stop(fail_stop), .bad_par(bad_par),
    .active(active), .start_ok(start_ok));

  urx_idle u_idle (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxs(rxs), .active(active),
    .start_ok(start_ok), .after_stop(idle_after_stop), .nine(len9),
    .par_on(par_on), .idle_evt(idle_evt));

  urx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .done(done), .word(word), .noise(noise),
    .fail_stop(fail_stop), .bad_par(bad_par), .idle_evt(idle_evt),
    .ack(flag_ack), .sleep_req(sleep_req), .addr_wake(wake_on_addr),
    .nine(len9), .data(rx_word), .full(rx_full), .f_noise(err_noise),
    .f_frame(err_frame), .f_over(err_overrun), .f_par(err_parity),
    .f_idle(idle_seen), .asleep(asleep));

  assign rx_busy = active;

  // R1
  stop_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_div == '0 && !rx_busy) |=> !rx_busy);
endmodule

// File: tb/sim_uart_wake_rx.sv
`timescale 1ns/1ps
module sim_uart_wake_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_in = 1'b1;
  logic [12:0] baud_div = 13'd1;
  logic        len9 = 1'b0, par_on = 1'b0, par_odd = 1'b0;
  logic        idle_after_stop = 1'b0, wake_on_addr = 1'b0;
  logic        sleep_req = 1'b0, flag_ack = 1'b0;
  logic [8:0]  rx_word;
  logic        rx_full, err_noise, err_frame, err_overrun, err_parity;
  logic        idle_seen, rx_busy, asleep;
  int          checks = 0, errors = 0;
  logic        busy_mid = 1'b0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  uart_wake_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_div(baud_div), .len9(len9),
    .par_on(par_on), .par_odd(par_odd), .idle_after_stop(idle_after_stop),
    .wake_on_addr(wake_on_addr), .sleep_req(sleep_req), .flag_ack(flag_ack),
    .rx_word(rx_word), .rx_full(rx_full), .err_noise(err_noise),
    .err_frame(err_frame), .err_overrun(err_overrun), .err_parity(err_parity),
    .idle_seen(idle_seen), .rx_busy(rx_busy), .asleep(asleep));

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); flag_ack = 1'b1;
    @(negedge clk); flag_ack = 1'b0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  // let any pending idle detection fire, then clear everything
  task automatic settle();
    wait_cyc(400);
    pulse_ack();
  endtask

  // pm: 0 none, 1 even, 2 odd; gbit: bit index to glitch at clock 8, -1 none
  task automatic send_frame(input logic [8:0] d, input int nd, input int pm,
                            input bit bad, input logic stop_v, input int gbit,
                            input int len);
    logic [11:0] fb;
    int n;
    logic p;
    fb = '0;
    n = 1;
    for (int i = 0; i < nd; i++) begin fb[n] = d[i]; n++; end
    if (pm != 0) begin
      p = 1'b0;
      for (int i = 0; i < nd; i++) p = p ^ d[i];
      if (pm == 2) p = ~p;
      if (bad) p = ~p;
      fb[n] = p; n++;
    end
    fb[n] = stop_v; n++;
    for (int b = 0; b < n; b++) begin
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        rx_in = (b == gbit && c == 8) ? ~fb[b] : fb[b];
        if (b == 3 && c == len / 2) busy_mid = rx_busy;
      end
    end
    @(negedge clk);
    rx_in = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] mask, d;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(40);
    // reset state
    chk("R8 reset full", {8'd0, rx_full}, 9'd0);
    chk("R8 reset flags", {4'd0, err_noise, err_frame, err_overrun, err_parity, idle_seen}, 9'd0);
    chk("R11 reset busy", {8'd0, rx_busy}, 9'd0);
    chk("R12 reset asleep", {8'd0, asleep}, 9'd0);

    // R2 R5 sweep over length and parity modes
    for (int nn = 0; nn < 2; nn++) begin
      for (int pm = 0; pm < 3; pm++) begin
        len9 = nn[0]; par_on = (pm != 0); par_odd = (pm == 2);
        mask = nn[0] ? 9'h1FF : 9'h0FF;
        for (int v = 0; v < 12; v++) begin
          d = (v == 0) ? 9'd0 : (v == 1) ? mask : (9'(v * 173 + 29) & mask);
          send_frame(d, nn[0] ? 9 : 8, pm, 1'b0, 1'b1, -1, 16);
          wait_cyc(16);
          chk("R2 word", rx_word, d);
          chk("R2 full", {8'd0, rx_full}, 9'd1);
          chk("R5 parity ok", {8'd0, err_parity}, 9'd0);
          chk("R6 stop ok", {8'd0, err_frame}, 9'd0);
          chk("R3 clean", {8'd0, err_noise}, 9'd0);
          pulse_ack();
        end
        if (pm != 0) begin
          d = 9'h0A5 & mask;
          send_frame(d, nn[0] ? 9 : 8, pm, 1'b1, 1'b1, -1, 16);
          wait_cyc(16);
          chk("R5 parity bad", {8'd0, err_parity}, 9'd1);
          chk("R5 word kept", rx_word, d);
          pulse_ack();
        end
      end
    end
    len9 = 1'b0; par_on = 1'b0; par_odd = 1'b0;
    settle();

    // R3 noise glitch in a data bit and in the start bit
    send_frame(9'h0C3, 8, 0, 1'b0, 1'b1, 4, 16);
    wait_cyc(16);
    chk("R3 noise data bit", {8'd0, err_noise}, 9'd1);
    chk("R3 vote keeps value", rx_word, 9'h0C3);
    pulse_ack();
    send_frame(9'h03C, 8, 0, 1'b0, 1'b1, 0, 16);
    wait_cyc(16);
    chk("R3 noise start bit", {8'd0, err_noise}, 9'd1);
    chk("R3 start vote", rx_word, 9'h03C);
    pulse_ack();

    // R6 framing error
    send_frame(9'h05A, 8, 0, 1'b0, 1'b0, -1, 16);
    wait_cyc(16);
    chk("R6 framing", {8'd0, err_frame}, 9'd1);
    chk("R6 full", {8'd0, rx_full}, 9'd1);
    chk("R6 word", rx_word, 9'h05A);
    settle();

    // R11 busy during frame
    send_frame(9'h011, 8, 0, 1'b0, 1'b1, -1, 16);
    chk("R11 busy mid", {8'd0, busy_mid}, 9'd1);
    wait_cyc(16);
    chk("R11 busy after", {8'd0, rx_busy}, 9'd0);
    // R7 overrun
    send_frame(9'h022, 8, 0, 1'b0, 1'b1, -1, 16);
    wait_cyc(16);
    chk("R7 overrun", {8'd0, err_overrun}, 9'd1);
    chk("R7 word kept", rx_word, 9'h011);
    pulse_ack();
    // R8 ack clears
    chk("R8 full cleared", {8'd0, rx_full}, 9'd0);
    chk("R8 flags cleared", {5'd0, err_noise, err_frame, err_overrun, err_parity}, 9'd0);
    settle();

    // R4 false start
    for (int c = 0; c < 4; c++) begin @(negedge clk); rx_in = 1'b0; end
    @(negedge clk); rx_in = 1'b1;
    wait_cyc(400);
    chk("R4 no word", {8'd0, rx_full}, 9'd0);
    chk("R4 no idle arm", {8'd0, idle_seen}, 9'd0);

    // R9 idle flag once per activity
    idle_after_stop = 1'b0;
    send_frame(9'h05A, 8, 0, 1'b0, 1'b1, -1, 16);
    chk("R9 idle not yet", {8'd0, idle_seen}, 9'd0);
    wait_cyc(200);
    chk("R9 idle set", {8'd0, idle_seen}, 9'd1);
    pulse_ack();
    wait_cyc(400);
    chk("R9 idle once", {8'd0, idle_seen}, 9'd0);
    settle();

    // R10 short vs after-stop counting, all-ones character
    idle_after_stop = 1'b0;
    send_frame(9'h0FF, 8, 0, 1'b0, 1'b1, -1, 16);
    wait_cyc(80);
    chk("R10 short counts in frame", {8'd0, idle_seen}, 9'd1);
    settle();
    idle_after_stop = 1'b1;
    send_frame(9'h0FF, 8, 0, 1'b0, 1'b1, -1, 16);
    wait_cyc(80);
    chk("R10 after stop not yet", {8'd0, idle_seen}, 9'd0);
    wait_cyc(100);
    chk("R10 after stop set", {8'd0, idle_seen}, 9'd1);
    idle_after_stop = 1'b0;
    settle();

    // R12 idle wakeup
    wake_on_addr = 1'b0;
    pulse_sleep();
    chk("R12 asleep", {8'd0, asleep}, 9'd1);
    send_frame(9'h055, 8, 0, 1'b0, 1'b1, -1, 16);
    wait_cyc(16);
    chk("R12 dropped", {8'd0, rx_full}, 9'd0);
    chk("R12 still asleep", {8'd0, asleep}, 9'd1);
    wait_cyc(250);
    chk("R12 woke", {8'd0, asleep}, 9'd0);
    chk("R12 no idle flag", {8'd0, idle_seen}, 9'd0);
    send_frame(9'h03C, 8, 0, 1'b0, 1'b1, -1, 16);
    wait_cyc(16);
    chk("R12 next word", rx_word, 9'h03C);
    chk("R12 next full", {8'd0, rx_full}, 9'd1);
    settle();

    // R13 address wakeup
    wake_on_addr = 1'b1;
    pulse_sleep();
    send_frame(9'h012, 8, 0, 1'b0, 1'b1, -1, 16);
    wait_cyc(16);
    chk("R13 dropped", {8'd0, rx_full}, 9'd0);
    wait_cyc(300);
    chk("R13 idle no wake", {8'd0, asleep}, 9'd1);
    send_frame(9'h092, 8, 0, 1'b0, 1'b1, -1, 16);
    wait_cyc(16);
    chk("R13 woke", {8'd0, asleep}, 9'd0);
    chk("R13 address word", rx_word, 9'h092);
    settle();
    len9 = 1'b1;
    pulse_sleep();
    send_frame(9'h0FF, 9, 0, 1'b0, 1'b1, -1, 16);
    wait_cyc(16);
    chk("R13 9-bit low msb dropped", {8'd0, rx_full}, 9'd0);
    send_frame(9'h101, 9, 0, 1'b0, 1'b1, -1, 16);
    wait_cyc(16);
    chk("R13 9-bit wake word", rx_word, 9'h101);
    chk("R13 9-bit awake", {8'd0, asleep}, 9'd0);
    len9 = 1'b0; wake_on_addr = 1'b0;
    settle();

    // R1 other divisors
    baud_div = 13'd3;
    for (int v = 0; v < 4; v++) begin
      d = 9'(v * 71 + 6) & 9'h0FF;
      send_frame(d, 8, 0, 1'b0, 1'b1, -1, 48);
      wait_cyc(48);
      chk("R1 divisor 3 word", rx_word, d);
      pulse_ack();
    end
    baud_div = 13'd0;
    wait_cyc(10);
    send_frame(9'h0AA, 8, 0, 1'b0, 1'b1, -1, 48);
    wait_cyc(48);
    chk("R1 zero divisor busy", {8'd0, busy_mid}, 9'd0);
    chk("R1 zero divisor nothing", {8'd0, rx_full}, 9'd0);
    baud_div = 13'd1;
    wait_cyc(20);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule